// File: doc/BRIEF.md
# SPI flash transaction engine

This block is a register-programmed SPI master that runs one short transaction at a time against a serial NOR flash. The host loads an opcode, a 24-bit address and up to four data bytes into byte-wide registers, then writes a control word whose flags choose which of those phases go out on the wire and whether the data phase reads or writes. Setting the go bit in that same write launches the transaction. The engine shifts every selected byte out most significant bit first in SPI mode 0 and captures the bytes returned in a read data phase.

Chip select is not tied to the transaction. A software bit drives the select pin directly, so a driver can lower it, run a command transaction, follow with any number of read-only or write-only transactions that stream data, and raise it again. A fast read is built this way: opcode, address and one dummy write byte, then read-only transactions for the data. A lock bit refuses new transactions. A go request that arrives while busy or locked is dropped and recorded in a sticky error bit.

Top module: `spi_xact_engine`

## Requirements
- R1: Register map by regAddr: 0 opcode, 1 address high byte, 2 address middle byte, 3 address low byte, 4 to 7 data bytes 0 to 3, 8 control, 9 misc. Control bits: 7 go/busy, 6 send opcode, 5 send address, 4 run a data phase, 3 data direction (1 write, 0 read), 1:0 data byte count minus one; bit 2 reads 0. Exactly the enabled phases go out, in the order opcode, address, data, and a data-only transaction sends neither opcode nor address.
- R2: Writing control with bit 7 set while idle and unlocked starts a transaction; control bit 7 reads 1 from the cycle after that write until the transaction ends, then reads 0.
- R3: The address phase sends the high, middle and low address bytes in that order.
- R4: The data phase moves count+1 bytes; a write sends data bytes starting at byte 0, a read stores the returned bytes into data byte 0 upward and leaves the higher data bytes unchanged.
- R5: Misc bit 0 drives csOut directly (reset value 1) and is not changed by transactions, so it stays low across chained transactions.
- R6: SPI mode 0: sckOut idles low, each half period lasts HALF_DIV clock cycles, mosiOut holds steady while sckOut is high, bytes go out MSB first and misoIn is sampled on the rising edge.
- R7: While misc bit 1 (lock) is set, a go request does not start a transaction and no SCK edges occur.
- R8: A go request while busy or locked is ignored and sets the sticky error flag read at misc bit 2; writing misc with bit 2 set clears it.
- R9: After reset control reads 0x00, misc reads 0x01, sckOut and mosiOut are 0.
- R10: During a read data phase mosiOut is driven 0 for every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| sckOut | output | 1 | SPI serial clock |
| mosiOut | output | 1 | SPI data to flash |
| misoIn | input | 1 | SPI data from flash |
| csOut | output | 1 | Chip select pin level |

## Verification
The hardest state to reach is a read-only transaction in the middle of a select window that was opened by an earlier transaction, because the returned bytes then depend on how many bytes the flash has already seen. The bench models a flash whose reply for each byte is a function of that byte's position since select fell, and runs an opcode, address and dummy byte followed by two read-only transactions without raising select. A go request aimed at a running transaction is reached by writing control again in the very next cycle after a launch.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
  localparam int REG_AW = 4;
  localparam int BYTE_W = 8;
  localparam int STEP_N = 8;  // opcode, 3 address, 4 data
  localparam int STEP_W = $clog2(STEP_N);
  localparam logic [REG_AW-1:0] A_OPC  = 4'd0;
  localparam logic [REG_AW-1:0] A_DAT0 = 4'd4;
  localparam logic [REG_AW-1:0] A_CTRL = 4'd8;
  localparam logic [REG_AW-1:0] A_MISC = 4'd9;

  typedef struct packed {
    logic              load;
    logic [STEP_W-1:0] step;
    logic              sample;
    logic              shift;
    logic              store;
    logic [1:0]        storeIdx;
    logic              finish;
  } xactStrobe_t;
endpackage

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [STEP_N-1:0]   stepEn,
  input  logic                wrDir,
  output xactStrobe_t         stb,
  output logic                sckHi,
  output logic                running
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [STEP_W-1:0] step;
  logic [DW-1:0]     divCnt;
  logic [2:0]        bitCnt;
  logic [STEP_W:0]   firstS, followS;
  logic              divTick;

  function automatic logic [STEP_W:0] findStep(input logic [STEP_N-1:0] en, input int from);
    findStep = '0;
    for (int i = STEP_N - 1; i >= 0; i--)
      if (i >= from && en[i]) findStep = {1'b1, STEP_W'(i)};
  endfunction

  always_comb begin
    firstS  = findStep(stepEn, 0);
    followS = findStep(stepEn, int'(step) + 1);
    divTick = running && (divCnt == DIV_LAST);
    stb = '0;
    if (start && !running) begin
      if (firstS[STEP_W]) begin
        stb.load = 1'b1;
        stb.step = firstS[STEP_W-1:0];
      end else begin
        stb.finish = 1'b1;
      end
    end else if (divTick) begin
      if (!sckHi) begin
        stb.sample = 1'b1;
      end else begin
        stb.shift = 1'b1;
        if (bitCnt == 3'd7) begin
          if (step[STEP_W-1] && !wrDir) begin
            stb.store    = 1'b1;
            stb.storeIdx = step[1:0];
          end
          if (followS[STEP_W]) begin
            stb.load = 1'b1;
            stb.step = followS[STEP_W-1:0];
          end else begin
            stb.finish = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      step    <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sckHi   <= 1'b0;
    end else if (stb.load) begin
      running <= 1'b1;
      step    <= stb.step;
      divCnt  <= '0;
      bitCnt  <= '0;
      sckHi   <= 1'b0;
    end else begin
      if (running) begin
        divCnt <= divTick ? '0 : divCnt + 1'b1;
        if (divTick) begin
          sckHi <= ~sckHi;
          if (sckHi) bitCnt <= bitCnt + 1'b1;
        end
      end
      if (stb.finish) running <= 1'b0;
    end
  end

  assert_sck_low_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (!sckHi && !running));
endmodule

// File: rtl/spi_xact_dp.sv
module spi_xact_dp
  import spi_xact_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  xactStrobe_t       stb,
  input  logic              sckHi,
  input  logic              misoIn,
  output logic              start,
  output logic [STEP_N-1:0] stepEn,
  output logic              wrDir,
  output logic              mosiOut,
  output logic              csOut
);
  logic [BYTE_W-1:0] opcodeR;
  logic [BYTE_W-1:0] addrR [0:2];
  logic [BYTE_W-1:0] dataR [0:3];
  logic              opEn, adEn, dtEn, busyR, lockR, errR, rxBit;
  logic [1:0]        cntR;
  logic [BYTE_W-1:0] shreg, loadVal, rxByte;
  logic              goReq;

  assign goReq  = regWe && (regAddr == A_CTRL) && regWdata[7];
  assign rxByte = {shreg[BYTE_W-2:0], rxBit};
  assign mosiOut = shreg[BYTE_W-1];

  always_comb begin
    stepEn[0]   = opEn;
    stepEn[3:1] = {3{adEn}};
    stepEn[4]   = dtEn;
    stepEn[5]   = dtEn && (cntR >= 2'd1);
    stepEn[6]   = dtEn && (cntR >= 2'd2);
    stepEn[7]   = dtEn && (cntR == 2'd3);
  end

  always_comb begin
    case (stb.step)
      3'd0:    loadVal = opcodeR;
      3'd1:    loadVal = addrR[0];
      3'd2:    loadVal = addrR[1];
      3'd3:    loadVal = addrR[2];
      default: loadVal = wrDir ? dataR[stb.step[1:0]] : '0;
    endcase
  end

  always_comb begin
    case (regAddr)
      A_OPC:   regRdata = opcodeR;
      4'd1:    regRdata = addrR[0];
      4'd2:    regRdata = addrR[1];
      4'd3:    regRdata = addrR[2];
      4'd4:    regRdata = dataR[0];
      4'd5:    regRdata = dataR[1];
      4'd6:    regRdata = dataR[2];
      4'd7:    regRdata = dataR[3];
      A_CTRL:  regRdata = {busyR, opEn, adEn, dtEn, wrDir, 1'b0, cntR};
      A_MISC:  regRdata = {5'b0, errR, lockR, csOut};
      default: regRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeR <= '0;
      addrR   <= '{default: '0};
      opEn <= 1'b0; adEn <= 1'b0; dtEn <= 1'b0; wrDir <= 1'b0; cntR <= '0;
      busyR <= 1'b0; start <= 1'b0;
      csOut <= 1'b1; lockR <= 1'b0; errR <= 1'b0;
      shreg <= '0; rxBit <= 1'b0;
    end else begin
      start <= 1'b0;
      if (regWe) begin
        case (regAddr)
          A_OPC: opcodeR <= regWdata;
          4'd1:  addrR[0] <= regWdata;
          4'd2:  addrR[1] <= regWdata;
          4'd3:  addrR[2] <= regWdata;
          A_CTRL: if (!busyR) begin
            opEn <= regWdata[6]; adEn <= regWdata[5];
            dtEn <= regWdata[4]; wrDir <= regWdata[3]; cntR <= regWdata[1:0];
            if (regWdata[7] && !lockR) begin
              busyR <= 1'b1;
              start <= 1'b1;
            end
          end
          A_MISC: begin
            csOut <= regWdata[0];
            lockR <= regWdata[1];
            if (regWdata[2]) errR <= 1'b0;
          end
          default: ;
        endcase
      end
      if (goReq && (busyR || lockR)) errR <= 1'b1;
      if (stb.finish) busyR <= 1'b0;
      if (stb.load)        shreg <= loadVal;
      else if (stb.finish) shreg <= '0;
      else if (stb.shift)  shreg <= rxByte;
      if (stb.sample) rxBit <= misoIn;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_data
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dataR[k] <= '0;
      else if (stb.store && stb.storeIdx == 2'(k))
        dataR[k] <= rxByte;
      else if (regWe && regAddr == A_DAT0 + REG_AW'(k))
        dataR[k] <= regWdata;
    end
  end

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && !stb.finish) |=> busyR);
  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockR && !busyR) |=> !busyR);
  assert_reject_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && (busyR || lockR)) |=> errR);
  assert_store_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.store |-> !wrDir);
  assert_cs_direct_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_MISC) |=> (csOut == $past(regWdata[0])));
  assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    sckHi |-> $stable(mosiOut));
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        sckOut,
  output logic        mosiOut,
  input  logic        misoIn,
  output logic        csOut
);
  xactStrobe_t       stb;
  logic              start, wrDir, running;
  logic [STEP_N-1:0] stepEn;

  spi_xact_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .sckHi(sckOut),
    .misoIn(misoIn), .start(start), .stepEn(stepEn), .wrDir(wrDir),
    .mosiOut(mosiOut), .csOut(csOut)
  );

  spi_xact_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn), .wrDir(wrDir),
    .stb(stb), .sckHi(sckOut), .running(running)
  );
endmodule

// File: tb/spi_xact_engine_tb.sv
module spi_xact_engine_tb;
  localparam int HALF = 2;
  localparam int NV = 7;
  // {ctrl[71:64], opcode[63:56], addr[55:32], data0..3[31:0]} ; go bit added by the loop
  localparam logic [71:0] VEC [NV] = '{
    {8'h40, 8'h06, 24'h000000, 32'hEEDDCCBB},
    {8'h60, 8'hD8, 24'h123456, 32'h01020304},
    {8'h59, 8'h01, 24'h000000, 32'h3CA75511},
    {8'h73, 8'h03, 24'hABCDEF, 32'h99887766},
    {8'h1A, 8'hFF, 24'h777777, 32'h11223344},
    {8'h78, 8'h0B, 24'h001020, 32'h00F0E0D0},
    {8'h10, 8'h00, 24'h000000, 32'h44556677}
  };

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, misoIn;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic sckOut, mosiOut, csOut;

  int checks = 0, fails = 0, logN = 0, winStart = 0, hiCnt = 0;
  logic [2:0] inBits = '0;
  logic [7:0] shIn = '0, curPat;
  logic [7:0] logB [0:255];

  spi_xact_engine #(.HALF_DIV(HALF)) u_dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input int n);
    return 8'h5A ^ 8'(n * 29);
  endfunction

  always_comb curPat = pat(logN - winStart);
  assign misoIn = curPat[3'd7 - inBits];

  always @(posedge sckOut) begin
    shIn = {shIn[6:0], mosiOut};
    if (inBits == 3'd7) begin
      logB[logN % 256] = shIn;
      logN = logN + 1;
    end
    inBits = inBits + 3'd1;
  end

  always @(posedge clk) if (sckOut) hiCnt = hiCnt + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitDone();
    logic [7:0] c;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      regRd(4'd8, c);
      if (!c[7]) break;
    end
  endtask

  task automatic csLow();
    winStart = logN;
    regWr(4'd9, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd, expB [0:7], dat [0:3];
    int expN, pre, base, h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    regRd(4'd8, rd); check(rd == 8'h00, "R9 control reset", rd, 8'h00);
    regRd(4'd9, rd); check(rd == 8'h01, "R9 misc reset", rd, 8'h01);
    check(sckOut == 1'b0 && mosiOut == 1'b0 && csOut == 1'b1, "R9 pins reset",
          {sckOut, mosiOut, csOut}, 3'b001);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      c = VEC[i][71:64];
      for (int k = 0; k < 4; k++) dat[k] = VEC[i][31-8*k -: 8];
      regWr(4'd0, VEC[i][63:56]);
      regWr(4'd1, VEC[i][55:48]);
      regWr(4'd2, VEC[i][47:40]);
      regWr(4'd3, VEC[i][39:32]);
      for (int k = 0; k < 4; k++) regWr(4'(4 + k), dat[k]);
      expN = 0;
      if (c[6]) begin expB[expN] = VEC[i][63:56]; expN++; end
      if (c[5]) begin
        expB[expN] = VEC[i][55:48]; expB[expN+1] = VEC[i][47:40];
        expB[expN+2] = VEC[i][39:32]; expN += 3;
      end
      pre = expN;
      if (c[4]) for (int k = 0; k <= int'(c[1:0]); k++) begin
        expB[expN] = c[3] ? dat[k] : 8'h00; expN++;
      end
      csLow();
      base = logN; h0 = hiCnt;
      regWr(4'd8, c | 8'h80);
      regRd(4'd8, rd); check(rd[7] == 1'b1, "R2 busy after go", rd[7], 1);
      waitDone();
      check(csOut == 1'b0, "R5 cs held low by software", csOut, 0);
      regWr(4'd9, 8'h01);
      check(logN - base == expN, "R1 byte count on wire", logN - base, expN);
      for (int b = 0; b < expN && b < 8; b++)
        check(logB[(base + b) % 256] == expB[b],
              (b < pre) ? "R3 command/address byte" : (c[3] ? "R4 write byte" : "R10 read mosi zero"),
              logB[(base + b) % 256], expB[b]);
      check(hiCnt - h0 == expN * 8 * HALF, "R6 sck high time", hiCnt - h0, expN * 8 * HALF);
      check(sckOut == 1'b0, "R6 sck idle low", sckOut, 0);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] e;
        e = (c[4] && !c[3] && k <= int'(c[1:0])) ? pat(pre + k) : dat[k];
        regRd(4'(4 + k), rd);
        check(rd == e, "R4 data register", rd, e);
      end
    end

    // R5 chained fast read: command + address + dummy, then two read-only transactions
    regWr(4'd0, 8'h0B); regWr(4'd1, 8'h00); regWr(4'd2, 8'h01); regWr(4'd3, 8'h02);
    regWr(4'd4, 8'h00);
    csLow();
    regWr(4'd8, 8'hF8); waitDone();
    regWr(4'd8, 8'h93); waitDone();
    check(csOut == 1'b0, "R5 cs low between transactions", csOut, 0);
    for (int k = 0; k < 4; k++) begin
      regRd(4'(4 + k), rd); check(rd == pat(5 + k), "R5 chained read data", rd, pat(5 + k));
    end
    regWr(4'd8, 8'h91); waitDone();
    regRd(4'd4, rd); check(rd == pat(9), "R5 stream continues byte0", rd, pat(9));
    regRd(4'd5, rd); check(rd == pat(10), "R5 stream continues byte1", rd, pat(10));
    regRd(4'd6, rd); check(rd == pat(7), "R4 upper byte kept", rd, pat(7));
    regWr(4'd9, 8'h01);

    // R8 go while busy
    base = logN; csLow();
    regWr(4'd8, 8'hC0);
    regWr(4'd8, 8'hF3);
    waitDone();
    check(logN - base == 1, "R8 busy go ignored", logN - base, 1);
    regRd(4'd8, rd); check(rd[6:0] == 7'h40, "R8 control fields kept", rd, 8'h40);
    regRd(4'd9, rd); check(rd[2] == 1'b1, "R8 error sticky", rd, 8'h04);
    regWr(4'd9, 8'h05);
    regRd(4'd9, rd); check(rd == 8'h01, "R8 error cleared", rd, 8'h01);

    // R7 lock
    regWr(4'd9, 8'h03);
    base = logN; h0 = hiCnt;
    regWr(4'd8, 8'hC0);
    regRd(4'd8, rd); check(rd[7] == 1'b0, "R7 locked go not busy", rd[7], 0);
    repeat (100) @(negedge clk);
    check(logN == base && hiCnt == h0, "R7 no sck while locked", hiCnt - h0, 0);
    regRd(4'd9, rd); check(rd == 8'h07, "R7 R8 lock error", rd, 8'h07);
    regWr(4'd9, 8'h05);
    regWr(4'd8, 8'hC0); waitDone();
    check(logN - base == 1, "R7 unlocked go runs", logN - base, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule